// File: doc/BRIEF.md
# PWM Period and Duty Monitor

This block watches a slow, asynchronous pulse-width-modulated status line and timestamps its edges with a free-running tick counter that advances once per clock. On every rising edge it reports the period since the previous rising edge. On every falling edge it reports the high time since the most recent rising edge. The period is also sorted into one of five frequency bands, centred on 10, 20, 30, 40 and 50 Hz, and the band is given as a small status code. A consumer can read the duty cycle as the ratio of the two tick counts.

When the line stops toggling, a deadline fires a fixed number of ticks after the last captured edge. The readings are then forced to a fixed 1-tick period with a high time of 0 (line stuck low) or 1 (line stuck high). Which of the two applies depends on the edge the detector was waiting for. The first edge after reset or after such a timeout only seeds the measurement. It never produces a false period.

Top module: `pwmMonitor`

## Requirements
- R1: After reset, `periodTicks` is 1, `highTicks` is 0, `measValid` is 0 and `bandCode` is 0. The detector waits for a rising edge.
- R2: On each rising edge after the first, `periodTicks` becomes the number of clock cycles since the previous rising edge, and `measValid` goes to 1. The output changes on the third rising clock edge after the input edge: two synchronizer stages, then the output register.
- R3: On each falling edge, `highTicks` becomes the number of clock cycles since the most recent rising edge. It has the same three-cycle latency as R2.
- R4: The first edge after reset or after a timeout leaves `periodTicks` at 1 and `measValid` at 0. If that first edge is a falling edge, `highTicks` becomes 1.
- R5: If no edge arrives for `TIMEOUT_TICKS` ticks while a rising edge is awaited, the outputs become `periodTicks`=1, `highTicks`=0, `measValid`=0. Expiry is `TIMEOUT_TICKS` cycles after the last edge was captured.
- R6: If the same timeout expires while a falling edge is awaited, the outputs become `periodTicks`=1, `highTicks`=1, `measValid`=0.
- R7: Every captured edge restarts the timeout. A signal whose edges are spaced less than `TIMEOUT_TICKS` apart never times out.
- R8: For band k (1 to 5), `bandCode` = k when the measured frequency f = `TICK_HZ`/`periodTicks` satisfies 10k−5 < f ≤ 10k+5. The decision is made by integer period thresholds, with no division.
- R9: `bandCode` is 0 (off) when `periodTicks` ≤ 1. It is 7 (invalid) for any other period outside all bands.
- R10: All timestamp and deadline arithmetic is modulo 2^`CNT_W`, so measurements that span a counter wrap stay exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the measurement tick |
| rst | input | 1 | Synchronous reset, active high |
| pwmIn | input | 1 | Asynchronous PWM line under measurement |
| periodTicks | output | CNT_W | Latest period in ticks (1 means no period) |
| highTicks | output | CNT_W | Latest high time in ticks |
| measValid | output | 1 | A real period has been measured since the last reset or timeout |
| bandCode | output | 3 | 0 off, 1 to 5 frequency band, 7 invalid |

## Verification
A wrong armed-edge state or a stale pulse-start timestamp shows up on `highTicks` or `periodTicks` three cycles after the next input edge, as a count that is off from the stimulus spacing. A lost "first edge" seed makes the first post-timeout edge report a huge, wrapped period and raise `measValid` where it must stay low. A misplaced deadline is caught by sampling exactly one cycle before and one cycle after the expected expiry. A wrong band threshold is exposed by driving periods one tick on either side of each boundary.

// File: rtl/pwmMonPkg.sv
package pwmMonPkg;

  // Strobes from the control module to the datapath, one cycle wide.
  typedef struct packed {
    logic rise;    // armed rising edge captured this cycle
    logic fall;    // armed falling edge captured this cycle
    logic first;   // this edge is the first since reset/timeout
    logic toLow;   // timeout while awaiting a rising edge
    logic toHigh;  // timeout while awaiting a falling edge
  } ctrlStrb_t;

  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_OFF     = 3'd0;
  localparam logic [CODE_W-1:0] CODE_INVALID = 3'd7;

endpackage

// File: rtl/pwmMonCtrl.sv
module pwmMonCtrl
  import pwmMonPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pwmIn,
  input  logic      deadlineHit,
  output ctrlStrb_t strb
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic lineLvl, prevLvl;
  logic armRise, firstPend;
  logic riseEdge, fallEdge, anyEdge;

  assign lineLvl  = syncQ[SYNC_STAGES-1];
  assign riseEdge = lineLvl & ~prevLvl;
  assign fallEdge = ~lineLvl & prevLvl;

  always_comb begin
    strb.rise   = armRise & riseEdge;
    strb.fall   = ~armRise & fallEdge;
    strb.first  = firstPend;
    anyEdge     = strb.rise | strb.fall;
    strb.toLow  = deadlineHit & ~anyEdge & armRise;
    strb.toHigh = deadlineHit & ~anyEdge & ~armRise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ     <= '0;
      prevLvl   <= 1'b0;
      armRise   <= 1'b1;
      firstPend <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], pwmIn};
      prevLvl <= lineLvl;
      if (strb.rise) armRise <= 1'b0;
      if (strb.fall) armRise <= 1'b1;
      if (anyEdge) firstPend <= 1'b0;
      else if (strb.toLow || strb.toHigh) firstPend <= 1'b1;
    end
  end

  // At most one event reaches the datapath per cycle.
  assert_one_event_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.rise, strb.fall, strb.toLow, strb.toHigh}));

  // After a captured rising edge the next captured edge cannot be a rising one.
  assert_alternate_R3: assert property (@(posedge clk) disable iff (rst)
    strb.rise |=> !strb.rise);

endmodule

// File: rtl/pwmMonDatapath.sv
module pwmMonDatapath
  import pwmMonPkg::*;
#(
  parameter int     CNT_W         = 32,
  parameter longint TIMEOUT_TICKS = 24_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrb_t        strb,
  output logic             deadlineHit,
  output logic [CNT_W-1:0] periodTicks,
  output logic [CNT_W-1:0] highTicks,
  output logic             measValid
);

  localparam logic [CNT_W-1:0] TIMEOUT_W = CNT_W'(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] ONE_W     = CNT_W'(1);

  logic [CNT_W-1:0] tickCnt, pulseStart, deadline, refStart;

  // A first edge is referenced one tick back, so its interval is exactly 1.
  assign refStart    = strb.first ? (tickCnt - ONE_W) : pulseStart;
  assign deadlineHit = (tickCnt == deadline);

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt     <= '0;
      pulseStart  <= '0;
      deadline    <= TIMEOUT_W;
      periodTicks <= ONE_W;
      highTicks   <= '0;
      measValid   <= 1'b0;
    end else begin
      tickCnt <= tickCnt + ONE_W;
      if (strb.rise) begin
        periodTicks <= tickCnt - refStart;
        pulseStart  <= tickCnt;
        measValid   <= ~strb.first;
      end
      if (strb.fall) highTicks <= tickCnt - refStart;
      if (strb.rise || strb.fall) deadline <= tickCnt + TIMEOUT_W;
      if (strb.toLow) begin
        periodTicks <= ONE_W;
        highTicks   <= '0;
        measValid   <= 1'b0;
      end
      if (strb.toHigh) begin
        periodTicks <= ONE_W;
        highTicks   <= ONE_W;
        measValid   <= 1'b0;
      end
    end
  end

  assert_first_rise_R4: assert property (@(posedge clk) disable iff (rst)
    strb.rise && strb.first |=> periodTicks == ONE_W && !measValid);

  assert_real_period_R2: assert property (@(posedge clk) disable iff (rst)
    strb.rise && !strb.first |=> measValid);

  assert_timeout_low_R5: assert property (@(posedge clk) disable iff (rst)
    strb.toLow |=> periodTicks == ONE_W && highTicks == '0 && !measValid);

  assert_timeout_high_R6: assert property (@(posedge clk) disable iff (rst)
    strb.toHigh |=> periodTicks == ONE_W && highTicks == ONE_W && !measValid);

endmodule

// File: rtl/pwmMonBands.sv
module pwmMonBands
  import pwmMonPkg::*;
#(
  parameter int     CNT_W      = 32,
  parameter longint TICK_HZ    = 24_000_000,
  parameter int     NUM_BANDS  = 5,
  parameter int     BAND_STEP  = 10,
  parameter int     BAND_HALF  = 5
) (
  input  logic [CNT_W-1:0]  periodTicks,
  output logic [CODE_W-1:0] bandCode
);

  logic [63:0]          periodWide;
  logic [NUM_BANDS-1:0] bandHit;

  assign periodWide = 64'(periodTicks);

  // f in (lo, hi]  <=>  ceil(TICK_HZ/hi) <= P < ceil(TICK_HZ/lo)
  for (genvar b = 0; b < NUM_BANDS; b++) begin : gBand
    localparam longint LO_HZ = longint'(BAND_STEP * (b + 1) - BAND_HALF);
    localparam longint HI_HZ = longint'(BAND_STEP * (b + 1) + BAND_HALF);
    localparam longint MIN_P = (TICK_HZ + HI_HZ - 1) / HI_HZ;
    localparam longint LIM_P = (TICK_HZ + LO_HZ - 1) / LO_HZ;
    assign bandHit[b] = (periodWide >= 64'(MIN_P)) && (periodWide < 64'(LIM_P));
  end

  always_comb begin
    bandCode = CODE_INVALID;
    for (int b = NUM_BANDS - 1; b >= 0; b--) begin
      if (bandHit[b]) bandCode = CODE_W'(b + 1);
    end
    if (periodTicks <= CNT_W'(1)) bandCode = CODE_OFF;
  end

endmodule

// File: rtl/pwmMonitor.sv
module pwmMonitor
  import pwmMonPkg::*;
#(
  parameter int     CNT_W         = 32,
  parameter longint TICK_HZ       = 24_000_000,
  parameter longint TIMEOUT_TICKS = 24_000_000,
  parameter int     SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwmIn,
  output logic [CNT_W-1:0] periodTicks,
  output logic [CNT_W-1:0] highTicks,
  output logic             measValid,
  output logic [2:0]       bandCode
);

  ctrlStrb_t strb;
  logic      deadlineHit;

  pwmMonCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst(rst), .pwmIn(pwmIn),
    .deadlineHit(deadlineHit), .strb(strb)
  );

  pwmMonDatapath #(.CNT_W(CNT_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .deadlineHit(deadlineHit),
    .periodTicks(periodTicks), .highTicks(highTicks), .measValid(measValid)
  );

  pwmMonBands #(.CNT_W(CNT_W), .TICK_HZ(TICK_HZ)) uBands (
    .periodTicks(periodTicks), .bandCode(bandCode)
  );

  // A real measurement never reads as "off".
  assert_valid_not_off_R9: assert property (@(posedge clk) disable iff (rst)
    measValid |-> bandCode != CODE_OFF);

endmodule

// File: tb/sim_pwmMonitor.sv
module sim_pwmMonitor;

  localparam int CW = 12;
  localparam int TO = 3000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwmIn = 1'b0;
  logic [CW-1:0] periodTicks, highTicks;
  logic          measValid;
  logic [2:0]    bandCode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwmMonitor #(.CNT_W(CW), .TICK_HZ(6000), .TIMEOUT_TICKS(TO)) u0 (
    .clk(clk), .rst(rst), .pwmIn(pwmIn),
    .periodTicks(periodTicks), .highTicks(highTicks),
    .measValid(measValid), .bandCode(bandCode)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drivePulse(int per, int hi);
    pwmIn = 1'b1; waitN(hi);
    pwmIn = 1'b0; waitN(per - hi);
  endtask

  // n full pulses, then one more rise and fall; check the last measurement.
  task automatic runPattern(string req, int per, int hi, int n, int expCode);
    repeat (n) drivePulse(per, hi);
    pwmIn = 1'b1; waitN(hi);
    pwmIn = 1'b0; waitN(5);
    chk(req, "period", periodTicks, per);
    chk(req, "high", highTicks, hi);
    chk(req, "valid", measValid, 1);
    chk(req, "band", bandCode, expCode);
  endtask

  task automatic testReset();  // R1
    chk("R1", "period", periodTicks, 1);
    chk("R1", "high", highTicks, 0);
    chk("R1", "valid", measValid, 0);
    chk("R1", "band", bandCode, 0);
  endtask

  task automatic testFirstAndLatency();  // R2 R3 R4
    pwmIn = 1'b1; waitN(5);
    chk("R4", "first rise period", periodTicks, 1);
    chk("R4", "first rise valid", measValid, 0);
    waitN(95);
    pwmIn = 1'b0; waitN(2);
    chk("R3", "high before latency", highTicks, 0);
    waitN(1);
    chk("R3", "high at latency", highTicks, 100);
    waitN(497);
    pwmIn = 1'b1; waitN(2);
    chk("R2", "period before latency", periodTicks, 1);
    waitN(1);
    chk("R2", "period at latency", periodTicks, 600);
    chk("R2", "valid", measValid, 1);
    chk("R8", "band 10Hz", bandCode, 1);
    waitN(147);
    pwmIn = 1'b0; waitN(450);
  endtask

  task automatic testBands();  // R8 R9
    runPattern("R8", 300, 100, 2, 2);
    runPattern("R8", 200, 50, 2, 3);
    runPattern("R8", 150, 75, 2, 4);
    runPattern("R8", 120, 60, 2, 5);
    runPattern("R8", 1199, 300, 2, 1);
    runPattern("R9", 1200, 300, 2, 7);
    runPattern("R8", 400, 100, 2, 1);
    runPattern("R8", 399, 100, 2, 2);
    runPattern("R8", 110, 40, 2, 5);
    runPattern("R9", 109, 40, 2, 7);
  endtask

  task automatic testSlowNoTimeout();  // R7
    runPattern("R7", 2900, 1450, 2, 7);
  endtask

  task automatic testWrap();  // R10
    for (int i = 0; i < 8; i++) begin
      pwmIn = 1'b1; waitN(5);
      if (i > 0) chk("R10", "period across wrap", periodTicks, 700);
      waitN(345);
      pwmIn = 1'b0; waitN(350);
    end
  endtask

  task automatic testTimeoutLow();  // R5 R7 R9
    pwmIn = 1'b1; waitN(100);
    pwmIn = 1'b0; waitN(3002);
    chk("R7", "valid just before deadline", measValid, 1);
    chk("R7", "high just before deadline", highTicks, 100);
    waitN(1);
    chk("R5", "period", periodTicks, 1);
    chk("R5", "high", highTicks, 0);
    chk("R5", "valid", measValid, 0);
    chk("R9", "band off", bandCode, 0);
  endtask

  task automatic testTimeoutHigh();  // R4 R6
    pwmIn = 1'b1; waitN(5);
    chk("R4", "rise after timeout period", periodTicks, 1);
    chk("R4", "rise after timeout valid", measValid, 0);
    waitN(2997);
    chk("R6", "high before deadline", highTicks, 0);
    waitN(1);
    chk("R6", "period", periodTicks, 1);
    chk("R6", "high", highTicks, 1);
    chk("R6", "valid", measValid, 0);
    pwmIn = 1'b0; waitN(5);
    chk("R4", "first fall high", highTicks, 1);
    chk("R4", "first fall period", periodTicks, 1);
    chk("R4", "first fall valid", measValid, 0);
    runPattern("R4", 300, 100, 2, 2);
  endtask

  initial begin
    waitN(3);
    rst = 1'b0;
    waitN(2);
    testReset();
    testFirstAndLatency();
    testBands();
    testSlowNoTimeout();
    testWrap();
    testTimeoutLow();
    testTimeoutHigh();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule